// File: doc/BRIEF.md
# Multi-Core External Interrupt Distributor

This block is the shared half of a small multiprocessor interrupt controller. It takes a bank of external interrupt lines, carrying identifiers from 32 upward, and conditions each one by its own two-bit trigger mode: active-high level, active-low level, rising edge or falling edge. It then hands the conditioned request to the cores. Each core receives a flat pending vector, one bit per line. The core's local interface arbitrates that vector and claims the line it will service by sending back the line's identifier.

Each line is routed in one of two ways. In the first, the line goes to exactly one core, named in its routing word. In the second, automatic delivery, the line is offered to every core at once. A latched edge request is withdrawn from all cores as soon as any one of them claims it. Software configures the block through a word-wide register port. The port holds a global enable, packed trigger words of sixteen lines each, and one routing word per line. Reads are combinational on the address. Writes take effect at the clock edge.

Top module: `ext_irq_distributor`

## Requirements
- R1: After a synchronous active-low reset, every pending output is 0. The enable word, all trigger words and all routing words read back as 0. This leaves each line active-high level, routed automatically, with the block disabled.
- R2: The control word at byte offset 0x0 holds the enable in bit 0. While this bit is 0, no bit of `core_pend` is set, whatever the inputs.
- R3: Line index i equals the identifier minus 32. Its 2-bit trigger code sits at bit 2*(i mod 16) of the word at offset 0x100 + 4*(i/16). Codes are 0 = level high, 1 = level low, 2 = rising edge, 3 = falling edge. Trigger words read back exactly as written.
- R4: A level-high line is active in the same cycle its input is 1. A level-low line is active in the same cycle its input is 0. The input and the `core_pend` bit are sampled in the same cycle.
- R5: An edge-mode line latches a request on its selected edge, using the mode in force at that clock. The request shows on `core_pend` after that clock and persists after the input returns. The opposite edge sets nothing. Putting the line into a level mode discards the latch.
- R6: A claim (`claim_en` bit with an identifier in `claim_id`) clears a latched edge request on that line. The request then drops from every core after that clock. A claim has no effect on a level-mode line. A new edge in the same cycle as a claim wins.
- R7: The routing word for line i sits at offset 0x1000 + 4*i. If bit 31 is set, the line appears only on the core whose number is in the low bits.
- R8: If bit 31 of the routing word is clear, the line appears on every core.
- R9: A routing word stores only bit 31 and the low clog2(NUM_CORES) bits. With four cores, writing 0xFFFFFFFF reads back 0x80000003, and writing 0x5 reads back 0x1.
- R10: The following read as 0 and are ignored on write:
  - addresses outside the three windows;
  - addresses inside a window whose low two bits are non-zero;
  - trigger words past the last line (0x138 and up with 224 lines);
  - routing words past the last line (0x1380 and up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | External lines, bit i is identifier 32+i, synchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| claim_en | input | NUM_CORES | Per-core claim strobe |
| claim_id | input | NUM_CORES*ID_W | Per-core claimed identifier, core c in bits c*ID_W upward |
| core_pend | output | NUM_CORES*NUM_LINES | Pending vector, bit c*NUM_LINES+i is line i offered to core c |

## Verification
The pending outputs are compared every cycle with a bench model while the bench applies three kinds of stimulus: sparse random input toggles, random claims and random reconfiguration. These are mixed with directed sequences.

Some directed tests drive input pulses that return to idle. These separate a latched edge request from a level that follows its input. Opposite-direction pulses show that each edge mode reacts to its own edge only.

Other directed tests separate cases that the random traffic might not isolate:
- Routing words with bit 31 both set and clear, and with stray high bits, separate single-core routing from automatic delivery.
- A claim placed on a level line versus on an edge line shows that only latched requests are withdrawn.
- Writes to addresses just past each window, and to misaligned addresses, separate a decode that is exact from one that aliases.

// File: rtl/ext_irq_pkg.sv
// Shared constants and types for the external interrupt distributor.
// Assumes a byte-addressed register port with 32-bit word accesses.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL_HI = 2'd0,
        TRIG_LVL_LO = 2'd1,
        TRIG_RISE   = 2'd2,
        TRIG_FALL   = 2'd3
    } trig_mode_e;

    localparam int unsigned CTL_OFS   = 32'h0000_0000;
    localparam int unsigned TRIG_OFS  = 32'h0000_0100;
    localparam int unsigned ROUTE_OFS = 32'h0000_1000;
    localparam int unsigned LINES_PER_TRIG_WORD = 16;

endpackage

// File: rtl/ext_irq_regs.sv
// Register file of the distributor: global enable, packed trigger words
// and one routing word per line. Reads are combinational on the address,
// writes take effect at the clock edge. Only aligned words inside the
// three windows decode; everything else reads zero and is not written.
module ext_irq_regs
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 224,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    output logic                           ctl_en,
    output logic [2*NUM_LINES-1:0]         trig_cfg,
    output logic [NUM_LINES-1:0]           route_dir,
    output logic [NUM_LINES*CW()-1:0]      route_core
);

    function automatic int CW();
        return (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;
    endfunction

    localparam int CORE_W = CW();
    localparam int TW     = (NUM_LINES + LINES_PER_TRIG_WORD - 1) / LINES_PER_TRIG_WORD;
    localparam int PADW   = 32 * TW;
    localparam int TIW    = (TW > 1) ? $clog2(TW) : 1;
    localparam int LIW    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

    localparam logic [ADDR_W-1:0] A_CTL   = ADDR_W'(CTL_OFS);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(TRIG_OFS);
    localparam logic [ADDR_W-1:0] A_TEND  = ADDR_W'(TRIG_OFS + 4 * TW);
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(ROUTE_OFS);
    localparam logic [ADDR_W-1:0] A_REND  = ADDR_W'(ROUTE_OFS + 4 * NUM_LINES);

    logic                  ctl_q;
    logic [PADW-1:0]       trig_q;
    logic [NUM_LINES-1:0]  dir_q;
    logic [NUM_LINES*CORE_W-1:0] core_q;

    logic                  hit_ctl, hit_trig, hit_route;
    logic [ADDR_W-1:0]     trig_off, route_off;
    logic [TIW-1:0]        tw_idx;
    logic [LIW-1:0]        rt_idx;

    // Decode the address into a window and a word index inside it.
    always_comb begin
        trig_off  = bus_addr - A_TRIG;
        route_off = bus_addr - A_ROUTE;
        tw_idx    = TIW'(trig_off >> 2);
        rt_idx    = LIW'(route_off >> 2);
        hit_ctl   = (bus_addr == A_CTL);
        hit_trig  = (bus_addr >= A_TRIG) && (bus_addr < A_TEND) && (bus_addr[1:0] == 2'b00);
        hit_route = (bus_addr >= A_ROUTE) && (bus_addr < A_REND) && (bus_addr[1:0] == 2'b00);
    end

    // Global enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ctl_q <= 1'b0;
        else if (bus_we && hit_ctl) ctl_q <= bus_wdata[0];
    end

    // Packed trigger words, one whole word per write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  trig_q <= '0;
        else if (bus_we && hit_trig) trig_q[int'(tw_idx)*32 +: 32] <= bus_wdata;
    end

    // Routing words, keeping only the direct flag and the core number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            core_q <= '0;
        end else if (bus_we && hit_route) begin
            dir_q[rt_idx]                       <= bus_wdata[31];
            core_q[int'(rt_idx)*CORE_W +: CORE_W] <= bus_wdata[CORE_W-1:0];
        end
    end

    // Read mux; trigger bits beyond the last line read as zero.
    always_comb begin
        bus_rdata = '0;
        if (hit_ctl) begin
            bus_rdata[0] = ctl_q;
        end else if (hit_trig) begin
            bus_rdata = trig_q[int'(tw_idx)*32 +: 32];
            for (int b = 0; b < 32; b++) begin
                if (int'(tw_idx) * 32 + b >= 2 * NUM_LINES) bus_rdata[b] = 1'b0;
            end
        end else if (hit_route) begin
            bus_rdata[31]         = dir_q[rt_idx];
            bus_rdata[CORE_W-1:0] = core_q[int'(rt_idx)*CORE_W +: CORE_W];
        end
    end

    assign ctl_en     = ctl_q;
    assign trig_cfg   = trig_q[2*NUM_LINES-1:0];
    assign route_dir  = dir_q;
    assign route_core = core_q;

endmodule

// File: rtl/ext_irq_cond.sv
// Per-line input conditioning. Level modes pass the input (or its
// inverse) straight through; edge modes latch a request on the selected
// edge, which a claim clears. Inputs are assumed synchronous to clk.
module ext_irq_cond
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 224
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_LINES-1:0]   irq_in,
    input  logic [2*NUM_LINES-1:0] trig_cfg,
    input  logic [NUM_LINES-1:0]   claim_hit,
    output logic [NUM_LINES-1:0]   edge_seen,
    output logic [NUM_LINES-1:0]   edge_pend,
    output logic [NUM_LINES-1:0]   line_act
);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        trig_mode_e mode;
        logic       prev_q;
        logic       pend_q;

        assign mode = trig_mode_e'(trig_cfg[2*i +: 2]);

        // Detect the edge selected by the line's mode.
        always_comb begin
            case (mode)
                TRIG_RISE: edge_seen[i] = irq_in[i] & ~prev_q;
                TRIG_FALL: edge_seen[i] = ~irq_in[i] & prev_q;
                default:   edge_seen[i] = 1'b0;
            endcase
        end

        // Track the previous input and the latched edge request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q <= 1'b0;
                pend_q <= 1'b0;
            end else begin
                prev_q <= irq_in[i];
                if (!mode[1])          pend_q <= 1'b0;
                else if (edge_seen[i]) pend_q <= 1'b1;
                else if (claim_hit[i]) pend_q <= 1'b0;
            end
        end

        // Conditioned request for this line.
        always_comb begin
            case (mode)
                TRIG_LVL_HI: line_act[i] = irq_in[i];
                TRIG_LVL_LO: line_act[i] = ~irq_in[i];
                default:     line_act[i] = pend_q;
            endcase
        end

        assign edge_pend[i] = pend_q;
    end

endmodule

// File: rtl/ext_irq_route.sv
// Fans each conditioned line out to the cores: to a single named core
// when the direct flag is set, to all cores otherwise. The global
// enable gates every output. A core number with no core behind it
// reaches nobody.
module ext_irq_route #(
    parameter int NUM_LINES = 224,
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input  logic                             ctl_en,
    input  logic [NUM_LINES-1:0]             line_act,
    input  logic [NUM_LINES-1:0]             route_dir,
    input  logic [NUM_LINES*CORE_W-1:0]      route_core,
    output logic [NUM_CORES*NUM_LINES-1:0]   core_pend
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            // Offer line i to core c when routing allows it.
            assign core_pend[c*NUM_LINES + i] = ctl_en & line_act[i] &
                (~route_dir[i] | (route_core[i*CORE_W +: CORE_W] == CORE_W'(c)));
        end
    end

endmodule

// File: rtl/ext_irq_distributor.sv
// Top of the shared external interrupt distributor. Combines the
// register file, per-line conditioning and the core fan-out, and turns
// the per-core claim identifiers into per-line clear strobes.
module ext_irq_distributor
    import ext_irq_pkg::*;
#(
    parameter int NUM_LINES = 224,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 16,
    parameter int ID_W      = 8,
    parameter int ID_BASE   = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_LINES-1:0]           irq_in,
    input  logic                           bus_we,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [31:0]                    bus_wdata,
    output logic [31:0]                    bus_rdata,
    input  logic [NUM_CORES-1:0]           claim_en,
    input  logic [NUM_CORES*ID_W-1:0]      claim_id,
    output logic [NUM_CORES*NUM_LINES-1:0] core_pend
);

    localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic                          ctl_en;
    logic [2*NUM_LINES-1:0]        trig_cfg;
    logic [NUM_LINES-1:0]          route_dir;
    logic [NUM_LINES*CORE_W-1:0]   route_core;
    logic [NUM_LINES-1:0]          claim_hit;
    logic [NUM_LINES-1:0]          edge_seen;
    logic [NUM_LINES-1:0]          edge_pend;
    logic [NUM_LINES-1:0]          line_act;

    // Translate each core's claimed identifier into a line strobe.
    always_comb begin
        claim_hit = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (claim_en[c]) begin
                if ((int'(claim_id[c*ID_W +: ID_W]) >= ID_BASE) &&
                    (int'(claim_id[c*ID_W +: ID_W]) < ID_BASE + NUM_LINES)) begin
                    claim_hit[int'(claim_id[c*ID_W +: ID_W]) - ID_BASE] = 1'b1;
                end
            end
        end
    end

    ext_irq_regs #(
        .NUM_LINES (NUM_LINES),
        .NUM_CORES (NUM_CORES),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .ctl_en     (ctl_en),
        .trig_cfg   (trig_cfg),
        .route_dir  (route_dir),
        .route_core (route_core)
    );

    ext_irq_cond #(
        .NUM_LINES (NUM_LINES)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .trig_cfg  (trig_cfg),
        .claim_hit (claim_hit),
        .edge_seen (edge_seen),
        .edge_pend (edge_pend),
        .line_act  (line_act)
    );

    ext_irq_route #(
        .NUM_LINES (NUM_LINES),
        .NUM_CORES (NUM_CORES),
        .CORE_W    (CORE_W)
    ) u_route (
        .ctl_en     (ctl_en),
        .line_act   (line_act),
        .route_dir  (route_dir),
        .route_core (route_core),
        .core_pend  (core_pend)
    );

endmodule

// File: rtl/ext_irq_chk.sv
// Property checker for the distributor, bound to the top. Watches the
// configuration, the edge latches, the claim strobes and the outputs.
module ext_irq_chk #(
    parameter int NUM_LINES = 224,
    parameter int NUM_CORES = 4,
    parameter int CORE_W    = 2
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ctl_en,
    input logic [NUM_LINES-1:0]           irq_in,
    input logic [2*NUM_LINES-1:0]         trig_cfg,
    input logic [NUM_LINES-1:0]           route_dir,
    input logic [NUM_LINES*CORE_W-1:0]    route_core,
    input logic [NUM_LINES-1:0]           claim_hit,
    input logic [NUM_LINES-1:0]           edge_seen,
    input logic [NUM_LINES-1:0]           edge_pend,
    input logic [NUM_CORES*NUM_LINES-1:0] core_pend
);

    // Disabled controller forwards nothing.
    assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en |-> (core_pend == '0));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ln
        logic [NUM_CORES-1:0] col;
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_col
            assign col[c] = core_pend[c*NUM_LINES + i];
        end

        assert_lvlhi_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_en && !route_dir[i] && trig_cfg[2*i +: 2] == 2'd0) |-> (col == {NUM_CORES{irq_in[i]}}));

        assert_lvllo_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_en && !route_dir[i] && trig_cfg[2*i +: 2] == 2'd1) |-> (col == {NUM_CORES{~irq_in[i]}}));

        assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_pend[i] && !claim_hit[i] && trig_cfg[2*i+1]) |=> edge_pend[i]);

        assert_lvlclr_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !trig_cfg[2*i+1] |=> !edge_pend[i]);

        assert_claim_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (claim_hit[i] && !edge_seen[i]) |=> !edge_pend[i]);

        assert_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
            route_dir[i] |-> ($countones(col) <= 1));

        assert_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !route_dir[i] |-> (col == '0 || col == '1));
    end

endmodule

bind ext_irq_distributor ext_irq_chk #(
    .NUM_LINES (NUM_LINES),
    .NUM_CORES (NUM_CORES),
    .CORE_W    (CORE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_en     (ctl_en),
    .irq_in     (irq_in),
    .trig_cfg   (trig_cfg),
    .route_dir  (route_dir),
    .route_core (route_core),
    .claim_hit  (claim_hit),
    .edge_seen  (edge_seen),
    .edge_pend  (edge_pend),
    .core_pend  (core_pend)
);

// File: tb/sim_ext_irq_distributor.sv
`timescale 1ns/1ps
module sim_ext_irq_distributor;

    localparam int N  = 224;
    localparam int NC = 4;
    localparam int VW = NC * N;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    irq_in = '0;
    logic            bus_we = 1'b0;
    logic [15:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NC-1:0]   claim_en = '0;
    logic [NC*8-1:0] claim_id = '0;
    logic [VW-1:0]   core_pend;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Reference model state
    bit       m_en;
    bit [1:0] m_trig [N];
    bit       m_dir  [N];
    bit [1:0] m_core [N];
    bit       m_pend [N];
    bit       m_prev [N];

    always #2 clk = ~clk;

    ext_irq_distributor u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .claim_en(claim_en), .claim_id(claim_id), .core_pend(core_pend)
    );

    task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] exp_vec();
        logic [VW-1:0] v = '0;
        for (int i = 0; i < N; i++) begin
            bit act;
            case (m_trig[i])
                2'd0:    act = irq_in[i];
                2'd1:    act = !irq_in[i];
                default: act = m_pend[i];
            endcase
            for (int c = 0; c < NC; c++)
                v[c*N+i] = m_en && act && (!m_dir[i] || m_core[i] == 2'(c));
        end
        return v;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [15:0] a);
        logic [31:0] r = '0;
        if (a == 16'h0) r[0] = m_en;
        else if (a >= 16'h100 && a < 16'h138 && a[1:0] == 2'b00) begin
            for (int k = 0; k < 16; k++) begin
                int idx = ((int'(a) - 'h100) / 4) * 16 + k;
                if (idx < N) r[2*k +: 2] = m_trig[idx];
            end
        end else if (a >= 16'h1000 && a < 16'h1380 && a[1:0] == 2'b00) begin
            int idx = (int'(a) - 'h1000) / 4;
            r = {m_dir[idx], 29'b0, m_core[idx]};
        end
        return r;
    endfunction

    function automatic logic [VW-1:0] lanes(input int i, input logic [NC-1:0] cm);
        logic [VW-1:0] v = '0;
        for (int c = 0; c < NC; c++) v[c*N+i] = cm[c];
        return v;
    endfunction

    // One clock: drive, advance the model, check all pending outputs.
    task automatic step(input logic we, input logic [15:0] a, input logic [31:0] d,
                        input logic [NC-1:0] ce, input logic [NC*8-1:0] ci,
                        input logic [N-1:0] nin, input string tag);
        bit np [N];
        @(negedge clk);
        bus_we = we; bus_addr = a; bus_wdata = d;
        claim_en = ce; claim_id = ci; irq_in = nin;
        for (int i = 0; i < N; i++) begin
            if (m_trig[i] < 2) np[i] = 1'b0;
            else begin
                bit e, cl;
                e = (m_trig[i] == 2) ? (nin[i] && !m_prev[i]) : (!nin[i] && m_prev[i]);
                cl = 1'b0;
                for (int c = 0; c < NC; c++)
                    if (ce[c] && int'(ci[c*8 +: 8]) == i + 32) cl = 1'b1;
                np[i] = e ? 1'b1 : (cl ? 1'b0 : m_pend[i]);
            end
        end
        @(posedge clk);
        for (int i = 0; i < N; i++) begin
            m_pend[i] = np[i];
            m_prev[i] = nin[i];
        end
        if (we) begin
            if (a == 16'h0) m_en = d[0];
            else if (a >= 16'h100 && a < 16'h138 && a[1:0] == 2'b00) begin
                for (int k = 0; k < 16; k++) begin
                    int idx = ((int'(a) - 'h100) / 4) * 16 + k;
                    if (idx < N) m_trig[idx] = d[2*k +: 2];
                end
            end else if (a >= 16'h1000 && a < 16'h1380 && a[1:0] == 2'b00) begin
                int idx = (int'(a) - 'h1000) / 4;
                m_dir[idx]  = d[31];
                m_core[idx] = d[1:0];
            end
        end
        #1;
        bus_we = 1'b0; claim_en = '0;
        chk(core_pend === exp_vec(), tag, core_pend, exp_vec());
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, VW'(bus_rdata), VW'(exp));
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
        step(1'b1, a, d, '0, '0, irq_in, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'd2024));
        m_en = 0;
        for (int i = 0; i < N; i++) begin
            m_trig[i] = 0; m_dir[i] = 0; m_core[i] = 0; m_pend[i] = 0; m_prev[i] = 0;
        end
        repeat (5) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state
        #1 chk(core_pend === '0, "R1 pend after reset", core_pend, '0);
        rd(16'h0000, 32'h0, "R1 ctl reset");
        rd(16'h0100, 32'h0, "R1 trig reset");
        rd(16'h1000, 32'h0, "R1 route reset");

        // R2: disabled with every input high
        step(0, 0, 0, '0, '0, '1, "R2 disabled");
        chk(core_pend === '0, "R2 no forward while off", core_pend, '0);
        wr(16'h0000, 32'h1, "R2 enable");
        chk(core_pend === '1, "R8 auto to all cores", core_pend, '1);
        rd(16'h0000, 32'h1, "R2 ctl readback");
        wr(16'h0000, 32'h0, "R2 disable");
        chk(core_pend === '0, "R2 off again", core_pend, '0);
        wr(16'h0000, 32'h1, "R2 re-enable");
        step(0, 0, 0, '0, '0, '0, "R4 inputs idle");

        // R3/R4: line 0 level low
        wr(16'h0100, 32'h1, "R3 trig write");
        rd(16'h0100, 32'h1, "R3 trig readback");
        chk(core_pend === lanes(0, 4'hF), "R4 level low active at 0", core_pend, lanes(0, 4'hF));

        // R7/R9: routing line 0
        wr(16'h1000, 32'h8000_0002, "R7 direct core2");
        chk(core_pend === lanes(0, 4'h4), "R7 only core 2", core_pend, lanes(0, 4'h4));
        rd(16'h1000, 32'h8000_0002, "R9 route readback");
        wr(16'h1000, 32'hFFFF_FFFF, "R7 direct core3");
        rd(16'h1000, 32'h8000_0003, "R9 stray bits dropped");
        chk(core_pend === lanes(0, 4'h8), "R7 only core 3", core_pend, lanes(0, 4'h8));
        wr(16'h1000, 32'h0000_0005, "R8 auto again");
        rd(16'h1000, 32'h0000_0001, "R9 auto readback");
        chk(core_pend === lanes(0, 4'hF), "R8 all cores", core_pend, lanes(0, 4'hF));
        wr(16'h0100, 32'h0, "R3 line0 level high");

        // R5/R6: line 17 rising, line 18 falling
        wr(16'h0104, 32'h0000_0038, "R3 edge modes");
        rd(16'h0104, 32'h0000_0038, "R3 word1 readback");
        v = '0; v[17] = 1'b1;
        step(0, 0, 0, '0, '0, v, "R5 rise");
        chk(core_pend === lanes(17, 4'hF), "R5 rising latched", core_pend, lanes(17, 4'hF));
        step(0, 0, 0, '0, '0, '0, "R5 rise release");
        chk(core_pend === lanes(17, 4'hF), "R5 latch persists", core_pend, lanes(17, 4'hF));
        step(0, 0, 0, 4'b0010, {8'd0, 8'd0, 8'd49, 8'd0}, '0, "R6 claim");
        chk(core_pend === '0, "R6 claim withdraws from all", core_pend, '0);
        v = '0; v[18] = 1'b1;
        step(0, 0, 0, '0, '0, v, "R5 fall line rise");
        chk(core_pend === '0, "R5 falling ignores rise", core_pend, '0);
        step(0, 0, 0, '0, '0, '0, "R5 fall");
        chk(core_pend === lanes(18, 4'hF), "R5 falling latched", core_pend, lanes(18, 4'hF));
        wr(16'h0104, 32'h0, "R5 to level");
        wr(16'h0104, 32'h0000_0030, "R5 back to edge");
        chk(core_pend === '0, "R5 latch dropped by level mode", core_pend, '0);

        // R6: claim on level line has no effect
        v = '0; v[0] = 1'b1;
        step(0, 0, 0, '0, '0, v, "R4 level high");
        step(0, 0, 0, 4'b0001, {24'd0, 8'd32}, v, "R6 level claim");
        chk(core_pend === lanes(0, 4'hF), "R6 level claim ignored", core_pend, lanes(0, 4'hF));

        // R10: unmapped and misaligned accesses
        wr(16'h0004, 32'hFFFF_FFFF, "R10 w 0x4");
        wr(16'h2000, 32'hFFFF_FFFF, "R10 w 0x2000");
        wr(16'h0138, 32'hFFFF_FFFF, "R10 w trig end");
        wr(16'h1380, 32'hFFFF_FFFF, "R10 w route end");
        wr(16'h1002, 32'hFFFF_FFFF, "R10 w misaligned");
        rd(16'h0004, 32'h0, "R10 r 0x4");
        rd(16'h2000, 32'h0, "R10 r 0x2000");
        rd(16'h0138, 32'h0, "R10 r trig end");
        rd(16'h1380, 32'h0, "R10 r route end");
        rd(16'h1002, 32'h0, "R10 r misaligned");
        rd(16'h0000, 32'h1, "R10 ctl untouched");
        rd(16'h0104, 32'h30, "R10 trig untouched");
        rd(16'h1000, 32'h1, "R10 route untouched");
        chk(core_pend === lanes(0, 4'hF), "R10 outputs untouched", core_pend, lanes(0, 4'hF));

        // Random traffic against the model: R4 R5 R6 R7 R8
        for (int s = 0; s < 3000; s++) begin
            logic [N-1:0]    nin = irq_in;
            logic [NC-1:0]   ce = '0;
            logic [NC*8-1:0] ci = '0;
            logic            we = 1'b0;
            logic [15:0]     a = '0;
            logic [31:0]     d = $urandom;
            for (int i = 0; i < N; i++) if ($urandom % 8 == 0) nin[i] = ~nin[i];
            for (int c = 0; c < NC; c++) if ($urandom % 4 == 0) begin
                ce[c] = 1'b1;
                ci[c*8 +: 8] = 8'($urandom % 256);
            end
            if ($urandom % 8 == 0) begin
                we = 1'b1;
                case ($urandom % 4)
                    0:       begin a = 16'h0; d[0] = ($urandom % 6 != 0); end
                    1:       a = 16'(16'h100 + 4 * ($urandom % 14));
                    default: a = 16'(16'h1000 + 4 * ($urandom % N));
                endcase
            end
            step(we, a, d, ce, ci, nin, "R4/R5/R6/R7/R8 random");
            if (s % 10 == 0) begin
                logic [15:0] ra;
                case ($urandom % 4)
                    0:       ra = 16'(16'h100 + 4 * ($urandom % 15));
                    1:       ra = 16'(16'h1000 + 4 * ($urandom % 225));
                    2:       ra = 16'($urandom);
                    default: ra = 16'h0;
                endcase
                rd(ra, exp_rd(ra), "R3/R9/R10 random read");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule